// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This block watches one dedicated external interrupt pin and six general-purpose pins, turns activity on them into two sticky event flags, and raises two interrupt request lines toward a processor core. All pins are first brought into the clock domain through a two-stage synchronizer. The external pin has a selectable sense: low level, any change, falling edge or rising edge. The six general pins share one pin-change flag, and a per-pin mask picks which of them may set it.

Software reaches the block through a small byte-wide register port. The port has a control register (sense mode and the two local enables), a flag register and a mask register. A flag clears when software writes a one to its bit, or when the core signals on an acknowledge input that it has entered the matching service routine. A request line is high only when its flag is set, its local enable is set and the global interrupt-enable input is high. In low-level mode the external request follows the synchronized pin directly, and the external flag is held at zero.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads 0x00 and both request outputs are low.
- R2: Register addresses: 0 = control (bits 1:0 sense mode, bit 6 external enable, bit 5 pin-change group enable); 1 = flags (bit 6 external flag, bit 5 pin-change flag); 2 = mask (bits 5:0, one per pin-change input). Bits not listed, and address 3, read as zero.
- R3: The pin-change flag sets when an input changes level, provided its mask bit is one and the group enable is one. A change on a masked-off pin, or any change while the group enable is zero, leaves the flag at zero.
- R4: A one-cycle pulse on ack_ext or ack_pc clears the matching flag.
- R5: Writing a one to a flag bit at address 1 clears that flag. Writing a zero leaves it unchanged.
- R6: In sense mode 00 (low level) the external flag reads zero, and the external request is high while the synchronized pin is low and the enables allow it. Entering mode 00 clears a flag that was already set.
- R7: irq_ext or irq_pc is high only when its flag is set (or, for irq_ext in mode 00, the pin is low), its local enable is set and gie is high. The external flag still sets while its enable is zero.
- R8: If a flag's set event and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R9: Sense mode 01 sets the external flag on either edge, 10 on falling edges only, and 11 on rising edges only.
- R10: A pin change applied between clock edges shows in the flag after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| ext_pin | input | 1 | Dedicated external interrupt pin |
| pc_pins | input | 6 | Pin-change inputs |
| gie | input | 1 | Global interrupt enable from the core |
| ack_ext | input | 1 | Core entered the external interrupt routine |
| ack_pc | input | 1 | Core entered the pin-change routine |
| irq_ext | output | 1 | External interrupt request |
| irq_pc | output | 1 | Pin-change interrupt request |

## Verification
The external pin is driven with rising and falling transitions in each of the four sense modes. This separates the edge modes from one another and from the any-change mode, and shows that low-level mode follows the pin without ever latching a flag. The pin-change group is toggled on masked and unmasked pins, with the group enable on and off, which tells per-pin masking apart from the group gate. Clear events are placed before, after and in the same cycle as a set event, which tells the set-wins priority apart from an ordinary clear. The request outputs are sampled with gie high and low, so the flag and the gating are checked separately.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int NUM_PC = 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd2;

    localparam int BIT_EXT = 6;
    localparam int BIT_PC  = 5;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign prev_o = st_q.prev;

    // R10: the synchronized value is the input from two edges ago
    a_r10_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_o == $past(st_q.s1));
endmodule

// File: rtl/irqc_ext_detect.sv
module irqc_ext_detect
    import irqc_pkg::*;
(
    input  logic   sync_i,
    input  logic   prev_i,
    input  sense_e sense_i,
    output logic   evt_o,
    output logic   level_req_o
);
    logic rise, fall;

    always_comb begin
        rise = sync_i & ~prev_i;
        fall = ~sync_i & prev_i;
        unique case (sense_i)
            SENSE_ANY:  evt_o = rise | fall;
            SENSE_FALL: evt_o = fall;
            SENSE_RISE: evt_o = rise;
            default:    evt_o = 1'b0;
        endcase
        level_req_o = (sense_i == SENSE_LOW) & ~sync_i;
    end
endmodule

// File: rtl/irqc_pc_detect.sv
module irqc_pc_detect #(
    parameter int N = 6
) (
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] mask_i,
    input  logic         grp_en_i,
    output logic         evt_o
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign hit[i] = (sync_i[i] ^ prev_i[i]) & mask_i[i];
    end

    assign evt_o = grp_en_i & (|hit);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_pin,
    input  logic [NUM_PC-1:0] pc_pins,
    input  logic              gie,
    input  logic              ack_ext,
    input  logic              ack_pc,
    output logic              irq_ext,
    output logic              irq_pc
);
    localparam int SW = NUM_PC + 1;

    typedef struct packed {
        sense_e            sense;
        logic              ext_en;
        logic              pc_en;
        logic [NUM_PC-1:0] mask;
        logic              ext_flag;
        logic              pc_flag;
    } regs_t;

    regs_t r_d, r_q;

    logic [SW-1:0] sync_w, prev_w;
    logic          ext_evt, pc_evt, level_req;
    logic          wr_ctrl, wr_flag, wr_mask;
    logic          clr_ext, clr_pc;
    logic          unused_wdata;

    irqc_sync #(.W(SW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({ext_pin, pc_pins}),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    irqc_ext_detect u_ext (
        .sync_i      (sync_w[SW-1]),
        .prev_i      (prev_w[SW-1]),
        .sense_i     (r_q.sense),
        .evt_o       (ext_evt),
        .level_req_o (level_req)
    );

    irqc_pc_detect #(.N(NUM_PC)) u_pc (
        .sync_i   (sync_w[NUM_PC-1:0]),
        .prev_i   (prev_w[NUM_PC-1:0]),
        .mask_i   (r_q.mask),
        .grp_en_i (r_q.pc_en),
        .evt_o    (pc_evt)
    );

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        r_d     = r_q;
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
        wr_mask = reg_wr && (reg_addr == ADDR_MASK);
        clr_ext = ack_ext | (wr_flag & reg_wdata[BIT_EXT]);
        clr_pc  = ack_pc  | (wr_flag & reg_wdata[BIT_PC]);

        if (wr_ctrl) begin
            r_d.sense  = sense_e'(reg_wdata[1:0]);
            r_d.ext_en = reg_wdata[BIT_EXT];
            r_d.pc_en  = reg_wdata[BIT_PC];
        end
        if (wr_mask) begin
            r_d.mask = reg_wdata[NUM_PC-1:0];
        end

        // set has priority over clear
        if (r_q.sense == SENSE_LOW) r_d.ext_flag = 1'b0;
        else if (ext_evt)           r_d.ext_flag = 1'b1;
        else if (clr_ext)           r_d.ext_flag = 1'b0;

        if (pc_evt)      r_d.pc_flag = 1'b1;
        else if (clr_pc) r_d.pc_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sense: SENSE_LOW, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[1:0]     = r_q.sense;
                reg_rdata[BIT_EXT] = r_q.ext_en;
                reg_rdata[BIT_PC]  = r_q.pc_en;
            end
            ADDR_FLAG: begin
                reg_rdata[BIT_EXT] = r_q.ext_flag;
                reg_rdata[BIT_PC]  = r_q.pc_flag;
            end
            ADDR_MASK: reg_rdata[NUM_PC-1:0] = r_q.mask;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_ext = gie & r_q.ext_en &
                     ((r_q.sense == SENSE_LOW) ? level_req : r_q.ext_flag);
    assign irq_pc  = gie & r_q.pc_en & r_q.pc_flag;

    // R6: level mode keeps the external flag at zero
    a_r6_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sense == SENSE_LOW) |=> !r_q.ext_flag);

    // R7: requests need the global enable and the local enable
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ext |-> (gie && r_q.ext_en)) and (irq_pc |-> (gie && r_q.pc_en)));

    // R3: the pin-change flag only rises after a detected change
    a_r3_pc_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.pc_flag && !pc_evt) |=> !r_q.pc_flag);

    // R4: acknowledge without a new event clears the flag
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pc && !pc_evt) |=> !r_q.pc_flag);

    // R8: a set event wins over any clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_evt && r_q.sense != SENSE_LOW) |=> r_q.ext_flag);
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    import irqc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ext_pin = 1'b0;
    logic [5:0] pc_pins = '0;
    logic       gie = 1'b0;
    logic       ack_ext = 1'b0;
    logic       ack_pc = 1'b0;
    logic       irq_ext, irq_pc;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .pc_pins(pc_pins), .gie(gie), .ack_ext(ack_ext), .ack_pc(ack_pc),
        .irq_ext(irq_ext), .irq_pc(irq_pc)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_flag(input string req, input string what, input logic [7:0] exp);
        logic [7:0] v;
        rd(ADDR_FLAG, v);
        chk(req, what, v, exp);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 8'h00);
        end
        chk("R1", "irq_ext after reset", {7'd0, irq_ext}, 8'h00);
        chk("R1", "irq_pc after reset", {7'd0, irq_pc}, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(ADDR_CTRL, 8'hFF);
        rd(ADDR_CTRL, v); chk("R2", "control reserved bits", v, 8'h63);
        wr(ADDR_MASK, 8'hFF);
        rd(ADDR_MASK, v); chk("R2", "mask reserved bits", v, 8'h3F);
        rd(2'd3, v);      chk("R2", "address 3 reads zero", v, 8'h00);
        wr(ADDR_FLAG, 8'hFF);
        chk_flag("R2", "flag reg after write", 8'h00);
        wr(ADDR_CTRL, 8'h00);
        wr(ADDR_MASK, 8'h00);
    endtask

    task automatic t_pinchange();
        gie = 1'b0;
        wr(ADDR_CTRL, 8'h20);
        wr(ADDR_MASK, 8'h05);
        pc_pins[1] = 1'b1; step(3);
        chk_flag("R3", "masked pin ignored", 8'h00);
        pc_pins[2] = 1'b1; step(2);
        chk_flag("R10", "not yet after two edges", 8'h00);
        step(1);
        chk_flag("R10", "set after third edge", 8'h20);
        chk("R7", "irq_pc low with gie low", {7'd0, irq_pc}, 8'h00);
        gie = 1'b1; #1;
        chk("R7", "irq_pc high with gie", {7'd0, irq_pc}, 8'h01);
        wr(ADDR_FLAG, 8'h00);
        chk_flag("R5", "write zero keeps flag", 8'h20);
        wr(ADDR_FLAG, 8'h20);
        chk_flag("R5", "write one clears flag", 8'h00);
        pc_pins[0] = 1'b1; step(3);
        chk_flag("R3", "pin0 change sets flag", 8'h20);
        ack_pc = 1'b1; step(1); ack_pc = 1'b0;
        chk_flag("R4", "ack_pc clears flag", 8'h00);
        chk("R4", "irq_pc low after ack", {7'd0, irq_pc}, 8'h00);
        wr(ADDR_CTRL, 8'h00);
        pc_pins[0] = 1'b0; step(3);
        chk_flag("R3", "group disabled ignores change", 8'h00);
        pc_pins = '0; step(3);
        gie = 1'b0;
    endtask

    task automatic t_ext_edges();
        ext_pin = 1'b0;
        wr(ADDR_CTRL, 8'h43);
        ext_pin = 1'b1; step(3);
        chk_flag("R9", "rise mode sets on rise", 8'h40);
        wr(ADDR_FLAG, 8'h40);
        ext_pin = 1'b0; step(3);
        chk_flag("R9", "rise mode ignores fall", 8'h00);
        wr(ADDR_CTRL, 8'h42);
        ext_pin = 1'b1; step(3);
        chk_flag("R9", "fall mode ignores rise", 8'h00);
        ext_pin = 1'b0; step(3);
        chk_flag("R9", "fall mode sets on fall", 8'h40);
        ack_ext = 1'b1; step(1); ack_ext = 1'b0;
        chk_flag("R4", "ack_ext clears flag", 8'h00);
        wr(ADDR_CTRL, 8'h41);
        ext_pin = 1'b1; step(3);
        chk_flag("R9", "any mode sets on rise", 8'h40);
        wr(ADDR_FLAG, 8'h40);
        ext_pin = 1'b0; step(3);
        chk_flag("R9", "any mode sets on fall", 8'h40);
        gie = 1'b1; #1;
        chk("R7", "irq_ext with gie", {7'd0, irq_ext}, 8'h01);
        gie = 1'b0; #1;
        chk("R7", "irq_ext without gie", {7'd0, irq_ext}, 8'h00);
        wr(ADDR_FLAG, 8'h40);
        wr(ADDR_CTRL, 8'h01);
        gie = 1'b1;
        ext_pin = 1'b1; step(3);
        chk_flag("R7", "flag sets with enable off", 8'h40);
        chk("R7", "irq_ext low with enable off", {7'd0, irq_ext}, 8'h00);
        gie = 1'b0;
        wr(ADDR_FLAG, 8'h40);
    endtask

    task automatic t_level();
        wr(ADDR_CTRL, 8'h41);
        ext_pin = 1'b0; step(3);
        chk_flag("R6", "flag set before level mode", 8'h40);
        gie = 1'b1;
        wr(ADDR_CTRL, 8'h40);
        step(1);
        chk_flag("R6", "entering level mode clears flag", 8'h00);
        chk("R6", "irq_ext while pin low", {7'd0, irq_ext}, 8'h01);
        ext_pin = 1'b1; step(1);
        chk("R6", "irq_ext after one edge", {7'd0, irq_ext}, 8'h01);
        step(1);
        chk("R6", "irq_ext drops with pin high", {7'd0, irq_ext}, 8'h00);
        ext_pin = 1'b0; step(3);
        chk("R6", "irq_ext back with pin low", {7'd0, irq_ext}, 8'h01);
        chk_flag("R6", "flag stays zero in level mode", 8'h00);
        gie = 1'b0;
        wr(ADDR_CTRL, 8'h00);
    endtask

    task automatic t_set_wins();
        ext_pin = 1'b0;
        wr(ADDR_CTRL, 8'h63);
        step(3);
        ext_pin = 1'b1; step(3);
        chk_flag("R8", "ext flag set first", 8'h40);
        ext_pin = 1'b0; step(3);
        ext_pin = 1'b1; step(2);
        wr(ADDR_FLAG, 8'h40);
        chk_flag("R8", "write clear loses to event", 8'h40);
        wr(ADDR_FLAG, 8'h40);
        chk_flag("R8", "later write clears", 8'h00);
        wr(ADDR_MASK, 8'h08);
        pc_pins[3] = 1'b1; step(2);
        ack_pc = 1'b1; step(1); ack_pc = 1'b0;
        chk_flag("R8", "ack loses to pin-change event", 8'h20);
        ack_pc = 1'b1; step(1); ack_pc = 1'b0;
        chk_flag("R8", "later ack clears", 8'h00);
    endtask

    initial begin
        #(5ns * 100000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_regmap();
        t_pinchange();
        t_ext_edges();
        t_level();
        t_set_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule